// File: doc/BRIEF.md
# Match-Compare System Timer with Cross-Domain Register Access

A memory-mapped timer peripheral for a system chip. A free-running 32-bit up-counter lives in its own slow timer clock domain. Software reaches it over a faster register bus through a simple port: valid, write, address and data, with combinational read data. Every value that has to travel between the two domains goes through a toggle request/acknowledge handshake. Software sees each handshake through a busy flag in an access-status register.

To read the live count, software writes the control register with bit 1 set. It then polls access-status bit 5 until it returns to 0 and reads the captured value at offset 0x10. Loading the counter and loading the match value work the same way, with busy flags at bits 4 and 0. When the count first becomes equal to the match value, status bit 0 is set. It stays set until software writes a one to it. The interrupt line is that status bit gated by interrupt-enable bit 0.

Each handshake has a two-state source machine on the bus side. HS_IDLE moves to HS_WAIT when a request is accepted; the request toggle flips and the payload is held. HS_WAIT moves back to HS_IDLE when the synchronised acknowledge toggle equals the request toggle. The busy flag is exactly "state is HS_WAIT". On the timer side, two flops synchronise the request toggle and a third detects the edge, which yields a one-cycle pulse. The registered toggle is echoed back as the acknowledge.

Top module: `match_timer`

## Requirements
- R1: After reset the match register reads 0xFFFFFFFF, status (0x14) reads 0, interrupt enable (0x1C) reads 0, control (0x20) reads 1 (counter running), access status (0x24) reads 0 and irq is 0.
- R2: The 32-bit counter increments once per timer clock while control bit 0 is 1, holds its value while control bit 0 is 0, and wraps from 0xFFFFFFFF to 0.
- R3: A write to control (0x20) with bit 1 set requests a count capture. Access-status bit 5 reads 1 from the next bus cycle until the captured count can be read at offset 0x10. Control bit 1 always reads 0.
- R4: A write to offset 0x10 loads the counter with the written value. Access-status bit 4 reads 1 until the load has reached the timer domain.
- R5: A write to offset 0x00 sets the match value. Access-status bit 0 reads 1 from the next bus cycle until the value has reached the timer domain. Reading 0x00 returns the last accepted match value.
- R6: A match write, count write or capture request that arrives while its own busy flag is 1 is ignored and leaves the transfer in flight unchanged.
- R7: Status bit 0 is set when the count becomes equal to the match value, including a match reached after the counter wraps.
- R8: Writing ones to status bits 3:0 clears them, and writing zeros leaves them unchanged. Status bits 3:1 always read 0.
- R9: irq is 1 exactly while status bit 0 and interrupt-enable bit 0 are both 1.
- R10: Interrupt-enable bit 0 is writable and reads back at offset 0x1C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| tmr_clk | input | 1 | Timer clock (counter domain) |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| req_valid | input | 1 | Bus access valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data (combinational, valid with the read request) |
| irq | output | 1 | Match interrupt, level |

## Verification
The assertions check on every bus cycle that a busy flag rises only after an accepted write, that a match write arriving while busy leaves the stored match value unchanged, and that a capture request raises its pending flag. They also check that status bit 0 stays set until a write of one clears it, and that irq falls only after a status or enable write. Only the bench scenarios can show the effects that cross domains. These are the exact value loaded into a stopped counter, counting versus holding, the match event after a wrap, and that the first of two back-to-back writes is the one that takes effect.

// File: rtl/mt_pkg.sv
package mt_pkg;
    localparam int unsigned ADDR_W   = 6;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned STS_W    = 4;

    localparam logic [ADDR_W-1:0] OFS_MATCH = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_ASTAT = 6'h24;

    localparam int unsigned AST_MATCH_BIT = 0;
    localparam int unsigned AST_LOAD_BIT  = 4;
    localparam int unsigned AST_CAP_BIT   = 5;

    typedef enum logic {
        HS_IDLE,
        HS_WAIT
    } hs_state_e;
endpackage

// File: rtl/xdom_hs.sv
module xdom_hs
    import mt_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         src_clk,
    input  logic         dst_clk,
    input  logic         rst_n,
    input  logic         src_start,
    input  logic [W-1:0] src_data,
    output logic         src_busy,
    output logic         src_done,
    output logic         dst_pulse,
    output logic [W-1:0] dst_data
);
    hs_state_e    state_q, state_d;
    logic         req_tgl;
    logic [W-1:0] hold_q;
    logic         ack_s1, ack_s2;
    logic         req_s1, req_s2, req_s3;
    logic         ack_back;

    assign ack_back = (ack_s2 == req_tgl);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE: if (src_start) state_d = HS_WAIT;
            HS_WAIT: if (ack_back)  state_d = HS_IDLE;
        endcase
    end

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            req_tgl <= 1'b0;
            hold_q  <= '0;
            ack_s1  <= 1'b0;
            ack_s2  <= 1'b0;
        end else begin
            ack_s1 <= req_s3;
            ack_s2 <= ack_s1;
            if (state_q == HS_IDLE && src_start) begin
                req_tgl <= ~req_tgl;
                hold_q  <= src_data;
            end
        end
    end

    always_comb begin
        src_busy = (state_q == HS_WAIT);
        src_done = (state_q == HS_WAIT) && ack_back;
    end

    always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) begin
            req_s1 <= 1'b0;
            req_s2 <= 1'b0;
            req_s3 <= 1'b0;
        end else begin
            req_s1 <= req_tgl;
            req_s2 <= req_s1;
            req_s3 <= req_s2;
        end
    end

    assign dst_pulse = req_s2 ^ req_s3;
    assign dst_data  = hold_q;
endmodule

// File: rtl/mt_tick_core.sv
module mt_tick_core #(
    parameter int unsigned CW = 32
) (
    input  logic          tmr_clk,
    input  logic          rst_n,
    input  logic          run_async,
    input  logic          load_pulse,
    input  logic [CW-1:0] load_val,
    input  logic          match_pulse,
    input  logic [CW-1:0] match_val,
    input  logic          cap_pulse,
    output logic [CW-1:0] snap,
    output logic          evt_tgl
);
    logic          run_s1, run_s2;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] match_q;
    logic          hit, hit_q;

    assign hit = (cnt_q == match_q);

    always_ff @(posedge tmr_clk or negedge rst_n) begin
        if (!rst_n) begin
            run_s1  <= 1'b1;
            run_s2  <= 1'b1;
            cnt_q   <= '0;
            match_q <= '1;
            hit_q   <= 1'b0;
            evt_tgl <= 1'b0;
            snap    <= '0;
        end else begin
            run_s1 <= run_async;
            run_s2 <= run_s1;
            if (load_pulse)   cnt_q <= load_val;
            else if (run_s2)  cnt_q <= cnt_q + 1'b1;
            if (match_pulse)  match_q <= match_val;
            hit_q <= hit;
            if (hit && !hit_q) evt_tgl <= ~evt_tgl;
            if (cap_pulse)    snap <= cnt_q;
        end
    end
endmodule

// File: rtl/match_timer.sv
module match_timer
    import mt_pkg::*;
(
    input  logic              bus_clk,
    input  logic              tmr_clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              irq
);
    logic              wr_match, wr_count, wr_stat, wr_ien, wr_ctrl;
    logic              mt_busy, cw_busy, cap_busy;
    logic              mt_done, cw_done, cap_done;
    logic              mt_pulse, cw_pulse, cap_pulse_raw;
    logic [DATA_W-1:0] mt_data, cw_data;
    logic [0:0]        cap_flag;
    logic [DATA_W-1:0] snap;
    logic              evt_tgl, evt_s1, evt_s2, evt_s3, evt_pulse;

    logic [DATA_W-1:0] match_sh;
    logic [DATA_W-1:0] cnt_rd;
    logic [STS_W-1:0]  sts_q;
    logic              ien_q;
    logic              run_q;

    always_comb begin
        wr_match = req_valid && req_write && (req_addr == OFS_MATCH);
        wr_count = req_valid && req_write && (req_addr == OFS_COUNT);
        wr_stat  = req_valid && req_write && (req_addr == OFS_STAT);
        wr_ien   = req_valid && req_write && (req_addr == OFS_IEN);
        wr_ctrl  = req_valid && req_write && (req_addr == OFS_CTRL);
    end

    xdom_hs #(.W(DATA_W)) u_hs_match (
        .src_clk(bus_clk), .dst_clk(tmr_clk), .rst_n(rst_n),
        .src_start(wr_match && !mt_busy), .src_data(req_wdata),
        .src_busy(mt_busy), .src_done(mt_done),
        .dst_pulse(mt_pulse), .dst_data(mt_data)
    );

    xdom_hs #(.W(DATA_W)) u_hs_load (
        .src_clk(bus_clk), .dst_clk(tmr_clk), .rst_n(rst_n),
        .src_start(wr_count && !cw_busy), .src_data(req_wdata),
        .src_busy(cw_busy), .src_done(cw_done),
        .dst_pulse(cw_pulse), .dst_data(cw_data)
    );

    xdom_hs #(.W(1)) u_hs_cap (
        .src_clk(bus_clk), .dst_clk(tmr_clk), .rst_n(rst_n),
        .src_start(wr_ctrl && req_wdata[1] && !cap_busy), .src_data(1'b1),
        .src_busy(cap_busy), .src_done(cap_done),
        .dst_pulse(cap_pulse_raw), .dst_data(cap_flag)
    );

    mt_tick_core #(.CW(DATA_W)) u_core (
        .tmr_clk(tmr_clk), .rst_n(rst_n), .run_async(run_q),
        .load_pulse(cw_pulse), .load_val(cw_data),
        .match_pulse(mt_pulse), .match_val(mt_data),
        .cap_pulse(cap_pulse_raw && cap_flag[0]),
        .snap(snap), .evt_tgl(evt_tgl)
    );

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_s1 <= 1'b0;
            evt_s2 <= 1'b0;
            evt_s3 <= 1'b0;
        end else begin
            evt_s1 <= evt_tgl;
            evt_s2 <= evt_s1;
            evt_s3 <= evt_s2;
        end
    end
    assign evt_pulse = evt_s2 ^ evt_s3;

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            match_sh <= '1;
            cnt_rd   <= '0;
            sts_q    <= '0;
            ien_q    <= 1'b0;
            run_q    <= 1'b1;
        end else begin
            if (wr_match && !mt_busy) match_sh <= req_wdata;
            if (cap_done)             cnt_rd   <= snap;
            if (wr_ien)               ien_q    <= req_wdata[0];
            if (wr_ctrl)              run_q    <= req_wdata[0];
            if (wr_stat)              sts_q    <= sts_q & ~req_wdata[STS_W-1:0];
            if (evt_pulse)            sts_q[0] <= 1'b1;
        end
    end

    always_comb begin
        rsp_rdata = '0;
        if (req_valid && !req_write) begin
            unique case (req_addr)
                OFS_MATCH: rsp_rdata = match_sh;
                OFS_COUNT: rsp_rdata = cnt_rd;
                OFS_STAT:  rsp_rdata = {{(DATA_W-STS_W){1'b0}}, sts_q};
                OFS_IEN:   rsp_rdata = {{(DATA_W-1){1'b0}}, ien_q};
                OFS_CTRL:  rsp_rdata = {{(DATA_W-1){1'b0}}, run_q};
                OFS_ASTAT: begin
                    rsp_rdata[AST_MATCH_BIT] = mt_busy;
                    rsp_rdata[AST_LOAD_BIT]  = cw_busy;
                    rsp_rdata[AST_CAP_BIT]   = cap_busy;
                end
                default:   rsp_rdata = '0;
            endcase
        end
    end

    assign irq = sts_q[0] & ien_q;
endmodule

// File: rtl/mt_chk.sv
module mt_chk
    import mt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              mt_busy,
    input logic              cap_busy,
    input logic [DATA_W-1:0] match_sh,
    input logic              sts0,
    input logic              irq
);
    logic wr_m, wr_s, wr_i, wr_c;
    assign wr_m = req_valid && req_write && (req_addr == OFS_MATCH);
    assign wr_s = req_valid && req_write && (req_addr == OFS_STAT);
    assign wr_i = req_valid && req_write && (req_addr == OFS_IEN);
    assign wr_c = req_valid && req_write && (req_addr == OFS_CTRL);

    assert_match_busy_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mt_busy) |-> $past(wr_m));

    assert_match_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_m && mt_busy) |=> $stable(match_sh));

    assert_cap_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c && req_wdata[1] && !cap_busy) |=> cap_busy);

    assert_sts_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sts0 && !(wr_s && req_wdata[0])) |=> sts0);

    assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_s || wr_i));
endmodule

bind match_timer mt_chk u_chk (
    .clk(bus_clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .mt_busy(mt_busy),
    .cap_busy(cap_busy), .match_sh(match_sh), .sts0(sts_q[0]), .irq(irq)
);

// File: tb/match_timer_test.sv
module match_timer_test;
    logic        bus_clk = 1'b0;
    logic        tmr_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [5:0]  req_addr  = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    always #5  bus_clk = ~bus_clk;
    always #20 tmr_clk = ~tmr_clk;

    match_timer uut (
        .bus_clk(bus_clk), .tmr_clk(tmr_clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .irq(irq)
    );

    always @(posedge bus_clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_fail++;
            n_run++;
            $display("FAIL watchdog: run did not end, act=%0d exp<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge bus_clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge bus_clk);
        req_valid = 1; req_write = 0; req_addr = a;
        #1 d = rsp_rdata;
        req_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge bus_clk);
    endtask

    task automatic poll_clear(input int b, input string tag);
        logic [31:0] v;
        for (int i = 0; i < 300; i++) begin
            rd(6'h24, v);
            if (!v[b]) return;
        end
        chk(tag, v[b], 0);
    endtask

    task automatic capture(input logic run, output logic [31:0] v);
        wr(6'h20, {30'b0, 1'b1, run});
        poll_clear(5, "R3 capture pending never cleared");
        rd(6'h10, v);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(6'h00, v); chk("R1 match reset", v, 32'hFFFF_FFFF);
        rd(6'h14, v); chk("R1 status reset", v, 0);
        rd(6'h1C, v); chk("R1 ien reset", v, 0);
        rd(6'h20, v); chk("R1 ctrl reset", v, 1);
        rd(6'h24, v); chk("R1 astat reset", v, 0);
        chk("R1 irq reset", irq, 0);
    endtask

    task automatic t_count_run;
        logic [31:0] a, b;
        capture(1, a);
        idle(40);
        capture(1, b);
        chk("R2 counts while enabled", (b > a), 1);
        wr(6'h20, 0);
        rd(6'h20, a); chk("R3 ctrl bit1 reads 0", a, 0);
        idle(40);
        capture(0, a);
        idle(60);
        capture(0, b);
        chk("R2 holds while disabled", b, a);
    endtask

    task automatic t_load;
        logic [31:0] v;
        wr(6'h10, 32'h0000_5000);
        rd(6'h24, v); chk("R4 load busy flag", v[4], 1);
        poll_clear(4, "R4 load busy never cleared");
        capture(0, v); chk("R4 loaded value", v, 32'h0000_5000);
        wr(6'h10, 32'h0000_1234);
        wr(6'h10, 32'h0000_9999);
        poll_clear(4, "R6 load busy never cleared");
        capture(0, v); chk("R6 second count write ignored", v, 32'h0000_1234);
    endtask

    task automatic t_match_wr;
        logic [31:0] v;
        wr(6'h00, 32'hAAAA_0055);
        rd(6'h24, v); chk("R5 match busy flag", v[0], 1);
        wr(6'h00, 32'hBBBB_0066);
        poll_clear(0, "R5 match busy never cleared");
        rd(6'h00, v); chk("R6 second match write ignored", v, 32'hAAAA_0055);
        wr(6'h00, 32'hFFFF_FFFF);
        poll_clear(0, "R5 match busy never cleared");
        rd(6'h00, v); chk("R5 match readback", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        wr(6'h10, 100);   poll_clear(4, "R4 busy");
        wr(6'h00, 120);   poll_clear(0, "R5 busy");
        wr(6'h14, 32'hF);
        wr(6'h1C, 1);
        rd(6'h1C, v); chk("R10 ien readback", v, 1);
        rd(6'h14, v); chk("R7 no match before run", v, 0);
        wr(6'h20, 1);
        idle(200);
        rd(6'h14, v); chk("R7 R8 match sets only bit0", v, 1);
        chk("R9 irq when set and enabled", irq, 1);
        wr(6'h14, 32'h0);
        rd(6'h14, v); chk("R8 write zero keeps status", v, 1);
        wr(6'h1C, 0);
        #1 chk("R9 irq masked by enable", irq, 0);
        wr(6'h1C, 1);
        #1 chk("R9 irq back on enable", irq, 1);
        wr(6'h14, 32'hF);
        rd(6'h14, v); chk("R8 W1C clears status", v, 0);
        chk("R9 irq low after clear", irq, 0);
        wr(6'h1C, 0);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        wr(6'h20, 0); idle(40);
        wr(6'h10, 32'hFFFF_FFF8); poll_clear(4, "R4 busy");
        wr(6'h00, 32'h0000_0002); poll_clear(0, "R5 busy");
        wr(6'h14, 32'hF);
        wr(6'h20, 1);
        idle(200);
        rd(6'h14, v); chk("R7 match after wrap", v, 1);
        capture(1, v); chk("R2 wrapped count small", (v < 32'h100), 1);
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        idle(3);
        t_reset();
        t_count_run();
        t_load();
        t_match_wr();
        t_irq();
        t_wrap();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule